// File: doc/BRIEF.md
# Dual-Port Interleaving Sample Multiplexer

This block merges two parallel sample ports into one sample stream for the output register of a converter. It runs on a fast clock at twice the input word rate. A one-cycle phase strobe marks the start of each input word period. In interleaved mode both ports are captured together on the strobe edge. The output register then takes the second port's previously captured sample on that edge, and the first port's freshly captured sample one fast cycle later. The output timing comes only from the fast clock and a registered phase flag, so the duty cycle of any slower word clock has no effect on it.

In the two single-port modes the block ignores the phase strobe. It passes the selected port to the output on every fast cycle, with two register stages of latency, and the other port never reaches the output. The fourth mode code is illegal. It raises an error flag and freezes the output register. An update strobe marks every cycle in which the output register takes a new sample.

Top module: `ilv_sample_mux`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears both port registers, the output word and the phase flag to zero after that edge, and it holds `out_upd` and `mode_err` low.
- R2: In interleaved mode (`mode_sel` = 2'b00), port values are captured only on edges where `word_phase` is high. Values presented in other cycles never reach `out_word`.
- R3: In interleaved mode, on an edge where `word_phase` is high, `out_word` takes the port-2 value captured at the previous strobe (zero after reset), and `out_upd` is high for that cycle.
- R4: In interleaved mode, on the edge after a strobe edge (with `word_phase` low), `out_word` takes the port-1 value captured at that strobe, and `out_upd` is high.
- R5: In port-1 mode (`mode_sel` = 2'b01), on every edge `out_word` takes the port-1 value sampled one edge earlier (zero for the first edge after reset), and `out_upd` is high. `word_phase` and port 2 have no effect.
- R6: In port-2 mode (`mode_sel` = 2'b10), on every edge `out_word` takes the port-2 value sampled one edge earlier, and `out_upd` is high. `word_phase` and port 1 have no effect.
- R7: With `mode_sel` = 2'b11, `mode_err` is high after each edge, `out_word` keeps its value, and `out_upd` stays low.
- R8: `out_upd` is high for exactly the cycles that follow an edge in which the output register was loaded. It is never high in a cycle where `out_word` was frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the input word rate |
| rst | input | 1 | Synchronous reset, active high |
| word_phase | input | 1 | One-cycle strobe marking the input word edge |
| port1_in | input | 12 | First input sample port |
| port2_in | input | 12 | Second input sample port |
| mode_sel | input | 2 | 00 interleave, 01 port 1 only, 10 port 2 only, 11 illegal |
| out_word | output | 12 | Output sample register |
| out_upd | output | 1 | High in each cycle after the output register is loaded |
| mode_err | output | 1 | High while the illegal mode code is applied |

## Verification
The in-line assertions check every cycle. They cover the load source of the output register in each mode, which captured port value it takes on strobe and half-period edges, the freeze in the illegal mode, and the cleared state after reset. Only the bench scenarios show the emitted order across whole word periods. These include the one-period delay of port 2 against port 1, the fact that off-strobe data and the unselected port never appear, and the value held across an illegal-mode stretch that follows live traffic.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   typedef enum logic [1:0] {
      MODE_ILV = 2'b00,
      MODE_P1  = 2'b01,
      MODE_P2  = 2'b10,
      MODE_BAD = 2'b11
   } ilv_mode_e;

   localparam int unsigned NUM_PORTS = 2;
   localparam int unsigned IDX_P1    = 0;
   localparam int unsigned IDX_P2    = 1;
endpackage

// File: rtl/ilv_port_reg.sv
module ilv_port_reg #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cap_en,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   if (W < 1) begin : g_bad_w
      $error("ilv_port_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)         q_out <= '0;
      else if (cap_en) q_out <= d_in;
   end
endmodule

// File: rtl/ilv_phase_track.sv
module ilv_phase_track (
   input  logic clk,
   input  logic rst,
   input  logic word_phase,
   input  logic ilv_active,
   output logic half_q
);
   always_ff @(posedge clk) begin
      if (rst) half_q <= 1'b0;
      else     half_q <= word_phase & ilv_active;
   end
endmodule

// File: rtl/ilv_out_sel.sv
module ilv_out_sel
   import ilv_pkg::*;
#(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [1:0]   mode,
   input  logic         word_phase,
   input  logic         half_q,
   input  logic [W-1:0] reg_p1,
   input  logic [W-1:0] reg_p2,
   output logic [W-1:0] out_word,
   output logic         out_upd,
   output logic         mode_err
);
   always_ff @(posedge clk) begin
      if (rst) begin
         out_word <= '0;
         out_upd  <= 1'b0;
         mode_err <= 1'b0;
      end else begin
         out_upd  <= 1'b0;
         mode_err <= (mode == MODE_BAD);
         case (mode)
            MODE_ILV: begin
               if (word_phase) begin
                  out_word <= reg_p2;
                  out_upd  <= 1'b1;
               end else if (half_q) begin
                  out_word <= reg_p1;
                  out_upd  <= 1'b1;
               end
            end
            MODE_P1: begin
               out_word <= reg_p1;
               out_upd  <= 1'b1;
            end
            MODE_P2: begin
               out_word <= reg_p2;
               out_upd  <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   AST_RESET_CLR: assert property (@(posedge clk)
      rst |=> (!out_upd && !mode_err && out_word == '0)); // R1
   AST_ILV_STROBE: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_ILV && word_phase) |=> (out_upd && out_word == $past(reg_p2))); // R3
   AST_ILV_HALF: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_ILV && half_q && !word_phase) |=> (out_upd && out_word == $past(reg_p1))); // R4
   AST_P1_PASS: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_P1) |=> (out_upd && out_word == $past(reg_p1))); // R5
   AST_P2_PASS: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_P2) |=> (out_upd && out_word == $past(reg_p2))); // R6
   AST_BAD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_BAD) |=> (mode_err && !out_upd && $stable(out_word))); // R7
   AST_ILV_IDLE: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_ILV && !word_phase && !half_q) |=> (!out_upd && $stable(out_word))); // R8
endmodule

// File: rtl/ilv_sample_mux.sv
module ilv_sample_mux
   import ilv_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 12
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                word_phase,
   input  logic [SAMPLE_W-1:0] port1_in,
   input  logic [SAMPLE_W-1:0] port2_in,
   input  logic [1:0]          mode_sel,
   output logic [SAMPLE_W-1:0] out_word,
   output logic                out_upd,
   output logic                mode_err
);
   if (SAMPLE_W < 1 || SAMPLE_W > 32) begin : g_bad_width
      $error("ilv_sample_mux: SAMPLE_W must lie in 1..32");
   end

   logic                ilv_active;
   logic                single_active;
   logic                cap_en;
   logic                half_q;
   logic [SAMPLE_W-1:0] port_d [NUM_PORTS];
   logic [SAMPLE_W-1:0] port_q [NUM_PORTS];

   assign ilv_active    = (mode_sel == MODE_ILV);
   assign single_active = (mode_sel == MODE_P1) || (mode_sel == MODE_P2);
   assign cap_en        = (ilv_active & word_phase) | single_active;
   assign port_d[IDX_P1] = port1_in;
   assign port_d[IDX_P2] = port2_in;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      ilv_port_reg #(.W(SAMPLE_W)) u_reg (
         .clk    (clk),
         .rst    (rst),
         .cap_en (cap_en),
         .d_in   (port_d[p]),
         .q_out  (port_q[p])
      );
   end

   ilv_phase_track u_phase (
      .clk        (clk),
      .rst        (rst),
      .word_phase (word_phase),
      .ilv_active (ilv_active),
      .half_q     (half_q)
   );

   ilv_out_sel #(.W(SAMPLE_W)) u_out (
      .clk        (clk),
      .rst        (rst),
      .mode       (mode_sel),
      .word_phase (word_phase),
      .half_q     (half_q),
      .reg_p1     (port_q[IDX_P1]),
      .reg_p2     (port_q[IDX_P2]),
      .out_word   (out_word),
      .out_upd    (out_upd),
      .mode_err   (mode_err)
   );

   AST_BAD_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == MODE_BAD) |=> ($stable(port_q[IDX_P1]) && $stable(port_q[IDX_P2]))); // R7
   AST_ILV_OFFSTROBE: assert property (@(posedge clk) disable iff (rst)
      (ilv_active && !word_phase) |=> ($stable(port_q[IDX_P1]) && $stable(port_q[IDX_P2]))); // R2
endmodule

// File: tb/tb_ilv_sample_mux.sv
module tb_ilv_sample_mux;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         word_phase = 1'b0;
   logic [W-1:0] port1_in = '0;
   logic [W-1:0] port2_in = '0;
   logic [1:0]   mode_sel = 2'b00;
   logic [W-1:0] out_word;
   logic         out_upd;
   logic         mode_err;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   ilv_sample_mux #(.SAMPLE_W(W)) dut (
      .clk(clk), .rst(rst), .word_phase(word_phase),
      .port1_in(port1_in), .port2_in(port2_in), .mode_sel(mode_sel),
      .out_word(out_word), .out_upd(out_upd), .mode_err(mode_err)
   );

   always #5 clk = ~clk;

   function automatic logic [W-1:0] rnd_word();
      return W'($urandom);
   endfunction

   function automatic logic [W-1:0] pick_port(input logic [1:0] m,
                                             input logic [W-1:0] a,
                                             input logic [W-1:0] b);
      return (m == 2'b01) ? a : b;
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   logic [W-1:0] prev_p2;
   logic [W-1:0] prev_sel;

   task automatic do_reset();
      rst = 1'b1;
      word_phase = 1'b0;
      tick();
      tick();
      chk("R1 word", out_word, '0);
      chk("R1 upd", W'(out_upd), '0);
      chk("R1 err", W'(mode_err), '0);
      rst = 1'b0;
      prev_p2  = '0;
      prev_sel = '0;
   endtask

   task automatic ilv_word(input logic [W-1:0] a, input logic [W-1:0] b);
      mode_sel = 2'b00;
      word_phase = 1'b1; port1_in = a; port2_in = b;
      tick();
      chk("R3 upd", W'(out_upd), 1);
      chk("R3 word", out_word, prev_p2);
      word_phase = 1'b0; port1_in = rnd_word(); port2_in = rnd_word();
      tick();
      chk("R4 upd", W'(out_upd), 1);
      chk("R4/R2 word", out_word, a);
      prev_p2 = b;
   endtask

   task automatic single_cycle(input logic [1:0] m, input logic [W-1:0] a, input logic [W-1:0] b);
      mode_sel = m;
      word_phase = 1'($urandom);
      port1_in = a; port2_in = b;
      tick();
      chk((m == 2'b01) ? "R5 upd" : "R6 upd", W'(out_upd), 1);
      chk((m == 2'b01) ? "R5 word" : "R6 word", out_word, prev_sel);
      prev_sel = pick_port(m, a, b);
   endtask

   task automatic bad_cycles(input int n);
      logic [W-1:0] held;
      held = out_word;
      mode_sel = 2'b11;
      for (int i = 0; i < n; i++) begin
         word_phase = 1'($urandom);
         port1_in = rnd_word(); port2_in = rnd_word();
         tick();
         chk("R7 err", W'(mode_err), 1);
         chk("R7/R8 upd", W'(out_upd), 0);
         chk("R7 word", out_word, held);
      end
   endtask

   initial begin
      void'($urandom(32'h1a2b3c));
      @(negedge clk);
      do_reset();

      // Directed: extreme codes, port 2 delayed by one word period
      ilv_word(12'hFFF, 12'h000);
      ilv_word(12'h000, 12'hFFF);
      ilv_word(12'hA5A, 12'h5A5);
      // Directed: illegal mode after live interleaved traffic
      bad_cycles(3);
      do_reset();
      single_cycle(2'b01, 12'h123, 12'hFFF);
      single_cycle(2'b01, 12'h456, 12'h000);
      single_cycle(2'b01, 12'h789, 12'hEEE);
      bad_cycles(2);
      do_reset();
      single_cycle(2'b10, 12'hFFF, 12'h321);
      single_cycle(2'b10, 12'h000, 12'h654);
      single_cycle(2'b10, 12'hCCC, 12'h987);

      // Constrained random blocks
      for (int blk = 0; blk < 60; blk++) begin
         int m;
         int len;
         m   = int'($urandom_range(0, 2));
         len = int'($urandom_range(2, 12));
         do_reset();
         for (int k = 0; k < len; k++) begin
            if (m == 0) ilv_word(rnd_word(), rnd_word());
            else        single_cycle(2'(m), rnd_word(), rnd_word());
         end
         if ($urandom_range(0, 3) == 0) bad_cycles(int'($urandom_range(1, 4)));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule